// File: doc/BRIEF.md
# Instruction length and cycle calculator

This block decodes one 8-bit opcode of a classic 8-bit microprocessor instruction set. It reports how many bytes the instruction occupies, its addressing mode and its base cycle count. The addressing mode is derived from the regular row, column and group fields of the opcode. Alongside the opcode it takes the context needed to resolve timing penalties. For indexed reads that context is the unindexed address and the X and Y index values. For relative branches it is the program counter, the 8-bit offset and whether the branch is taken. From these it forms the total cycle count.

Any opcode outside the official map raises an illegal flag. A cycle tally, selected by a parameter, adds the total of every legal opcode presented with a valid strobe. A timing model or trace analyser can use the block to cost a stream of executed instructions without running them.

Top module: `instr_timing`

## Requirements
- R1: Length is 1 byte for implied and accumulator modes (BRK included), 2 bytes for immediate, zero page, zero page indexed, both indirect zero-page forms and relative, and 3 bytes for absolute, absolute indexed and absolute indirect.
- R2: The mode output uses the codes implied 0, accumulator 1, immediate 2, zero page 3, zero page X 4, zero page Y 5, absolute 6, absolute X 7, absolute Y 8, absolute indirect 9, indexed indirect 10, indirect indexed 11, relative 12. LDX and STX use the Y-indexed zero page form, and LDX uses the Y-indexed absolute form.
- R3: Base counts for reads are immediate 2, zero page 3, zero page indexed 4, absolute 4, absolute indexed 4, indexed indirect 6 and indirect indexed 5.
- R4: Stores take 5 cycles with absolute X or Y and 6 with indirect indexed, with no penalty. Shifts, rotates, increments and decrements take 5 on zero page, 6 on zero page X, 6 on absolute, 7 on absolute X and 2 on the accumulator, with no penalty.
- R5: JMP absolute takes 3 cycles, JMP indirect 5, JSR, RTS and RTI 6, and BRK 7. Pushes take 3, pulls 4, and other implied register and flag operations 2.
- R6: Reads in absolute X, absolute Y or indirect indexed mode add one cycle when the 16-bit sum of the unindexed address and the zero-extended index differs from that address in bits 15..8.
- R7: A branch takes 2 cycles when not taken and 3 when taken. It takes 4 when taken and the target (branch address + 2 + sign-extended offset, modulo 2^16) lies in a different 256-byte page from branch address + 2.
- R8: Opcodes outside the official map, including every opcode with bits 1..0 = 11, assert the illegal flag and report length 1, mode 0 and zero base and total cycles.
- R9: With the tally enabled, each rising clock edge with the valid strobe high and a legal opcode adds the total cycle count to the 32-bit tally. Without the strobe, or with an illegal opcode, the tally is unchanged.
- R10: A synchronous active-high reset clears the tally and takes priority over the valid strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Strobe: count this instruction into the tally |
| opcode_i | input | 8 | Opcode under evaluation |
| base_addr_i | input | 16 | Unindexed address (absolute operand or pointer read from zero page) |
| idx_x_i | input | 8 | X index value |
| idx_y_i | input | 8 | Y index value |
| br_off_i | input | 8 | Signed branch offset |
| br_taken_i | input | 1 | Branch condition is met |
| pc_i | input | 16 | Address of the opcode byte |
| len_o | output | 2 | Instruction length in bytes |
| mode_o | output | 4 | Addressing mode code |
| base_cyc_o | output | 4 | Cycle count before penalties |
| total_cyc_o | output | 4 | Cycle count including penalties |
| illegal_o | output | 1 | Opcode is not in the official map |
| tally_o | output | 32 | Running cycle sum |

## Verification
The hardest case to reach is a taken branch whose own opcode sits in one page while the byte after the branch already lies in the next page. Here the penalty must be judged against the post-branch address and not the opcode address. The stimulus table places branches at 0x10FE and 0xFFFE with small forward offsets. It also uses backward offsets that fall below a page start, and indexed reads whose sum just crosses or just misses a page edge with X and Y set differently. These show that the right index is chosen and that stores never pay the penalty.

// File: rtl/instr_timing_pkg.sv
package instr_timing_pkg;

   localparam int CYC_W = 4;
   localparam int LEN_W = 2;

   typedef enum logic [3:0] {
      AM_IMP = 4'd0,
      AM_ACC = 4'd1,
      AM_IMM = 4'd2,
      AM_ZP  = 4'd3,
      AM_ZPX = 4'd4,
      AM_ZPY = 4'd5,
      AM_ABS = 4'd6,
      AM_ABX = 4'd7,
      AM_ABY = 4'd8,
      AM_IND = 4'd9,
      AM_IZX = 4'd10,
      AM_IZY = 4'd11,
      AM_REL = 4'd12
   } addr_mode_e;

   typedef struct packed {
      addr_mode_e             mode;
      logic [LEN_W-1:0]       len;
      logic [CYC_W-1:0]       base_cyc;
      logic                   idx_pen;   // indexed read, may pay page penalty
      logic                   use_y;     // penalty index is Y
      logic                   branch;
      logic                   illegal;
   } op_info_t;

   function automatic logic [LEN_W-1:0] mode_len(addr_mode_e m);
      case (m)
         AM_IMP, AM_ACC:                 mode_len = 2'd1;
         AM_ABS, AM_ABX, AM_ABY, AM_IND: mode_len = 2'd3;
         default:                        mode_len = 2'd2;
      endcase
   endfunction

endpackage

// File: rtl/opc_decode.sv
module opc_decode
   import instr_timing_pkg::*;
(
   input  logic [7:0] opcode_i,
   output op_info_t   info_o
);

   logic [1:0] grp;
   logic [2:0] col;
   logic [2:0] row;
   logic       is_store;
   logic       is_rmw;

   addr_mode_e       mode;
   logic [CYC_W-1:0] cyc;
   logic             ok;
   logic             pen;
   logic             ysel;
   logic             br;

   assign grp      = opcode_i[1:0];
   assign col      = opcode_i[4:2];
   assign row      = opcode_i[7:5];
   assign is_store = (row == 3'd4);
   assign is_rmw   = !(row == 3'd4 || row == 3'd5);

   always_comb begin
      mode = AM_IMP;
      cyc  = '0;
      ok   = 1'b0;
      pen  = 1'b0;
      ysel = 1'b0;
      br   = 1'b0;
      case (grp)
         // accumulator arithmetic / load / store group
         2'b01: begin
            ok = !(is_store && col == 3'd2);
            case (col)
               3'd0: begin mode = AM_IZX; cyc = 4'd6; end
               3'd1: begin mode = AM_ZP;  cyc = 4'd3; end
               3'd2: begin mode = AM_IMM; cyc = 4'd2; end
               3'd3: begin mode = AM_ABS; cyc = 4'd4; end
               3'd4: begin
                  mode = AM_IZY; ysel = 1'b1; pen = !is_store;
                  cyc  = is_store ? 4'd6 : 4'd5;
               end
               3'd5: begin mode = AM_ZPX; cyc = 4'd4; end
               3'd6: begin
                  mode = AM_ABY; ysel = 1'b1; pen = !is_store;
                  cyc  = is_store ? 4'd5 : 4'd4;
               end
               default: begin
                  mode = AM_ABX; pen = !is_store;
                  cyc  = is_store ? 4'd5 : 4'd4;
               end
            endcase
         end
         // shift / rotate / inc / dec and X register group
         2'b10: begin
            case (col)
               3'd0: begin ok = (row == 3'd5); mode = AM_IMM; cyc = 4'd2; end
               3'd1: begin ok = 1'b1; mode = AM_ZP; cyc = is_rmw ? 4'd5 : 4'd3; end
               3'd2: begin
                  ok   = 1'b1;
                  mode = row[2] ? AM_IMP : AM_ACC;
                  cyc  = 4'd2;
               end
               3'd3: begin ok = 1'b1; mode = AM_ABS; cyc = is_rmw ? 4'd6 : 4'd4; end
               3'd4: begin ok = 1'b0; end
               3'd5: begin
                  ok   = 1'b1;
                  mode = is_rmw ? AM_ZPX : AM_ZPY;
                  cyc  = is_rmw ? 4'd6 : 4'd4;
               end
               3'd6: begin ok = !is_rmw; mode = AM_IMP; cyc = 4'd2; end
               default: begin
                  ok = !is_store;
                  if (row == 3'd5) begin
                     mode = AM_ABY; cyc = 4'd4; pen = 1'b1; ysel = 1'b1;
                  end else begin
                     mode = AM_ABX; cyc = 4'd7;
                  end
               end
            endcase
         end
         // control flow, stack, flags and Y register group
         2'b00: begin
            case (col)
               3'd0: begin
                  case (row)
                     3'd0: begin ok = 1'b1; mode = AM_IMP; cyc = 4'd7; end
                     3'd1: begin ok = 1'b1; mode = AM_ABS; cyc = 4'd6; end
                     3'd2, 3'd3: begin ok = 1'b1; mode = AM_IMP; cyc = 4'd6; end
                     3'd4: begin ok = 1'b0; end
                     default: begin ok = 1'b1; mode = AM_IMM; cyc = 4'd2; end
                  endcase
               end
               3'd1: begin ok = (row == 3'd1) || row[2]; mode = AM_ZP; cyc = 4'd3; end
               3'd2: begin
                  ok   = 1'b1;
                  mode = AM_IMP;
                  if (row[2])      cyc = 4'd2;
                  else if (row[0]) cyc = 4'd4;
                  else             cyc = 4'd3;
               end
               3'd3: begin
                  ok = (row != 3'd0);
                  case (row)
                     3'd2:    begin mode = AM_ABS; cyc = 4'd3; end
                     3'd3:    begin mode = AM_IND; cyc = 4'd5; end
                     default: begin mode = AM_ABS; cyc = 4'd4; end
                  endcase
               end
               3'd4: begin ok = 1'b1; mode = AM_REL; cyc = 4'd2; br = 1'b1; end
               3'd5: begin ok = !is_rmw; mode = AM_ZPX; cyc = 4'd4; end
               3'd6: begin ok = 1'b1; mode = AM_IMP; cyc = 4'd2; end
               default: begin ok = (row == 3'd5); mode = AM_ABX; cyc = 4'd4; pen = 1'b1; end
            endcase
         end
         default: ok = 1'b0;
      endcase

      if (!ok) begin
         mode = AM_IMP;
         cyc  = '0;
         pen  = 1'b0;
         ysel = 1'b0;
         br   = 1'b0;
      end
   end

   always_comb begin
      info_o.mode     = mode;
      info_o.len      = mode_len(mode);
      info_o.base_cyc = cyc;
      info_o.idx_pen  = pen;
      info_o.use_y    = ysel;
      info_o.branch   = br;
      info_o.illegal  = !ok;
   end

endmodule

// File: rtl/page_cross.sv
module page_cross #(
   parameter int ADDR_W    = 16,
   parameter int PAGE_BITS = 8,
   parameter int IDX_W     = 8
) (
   input  logic [ADDR_W-1:0] base_addr_i,
   input  logic [IDX_W-1:0]  index_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [7:0]        br_off_i,
   output logic              idx_cross_o,
   output logic              br_cross_o
);

   localparam int PAGE_MSB = ADDR_W - 1;
   localparam int EXT_W    = ADDR_W - 8;
   localparam int IEXT_W   = ADDR_W - IDX_W;

   logic [ADDR_W-1:0] eff_addr;
   logic [ADDR_W-1:0] next_pc;
   logic [ADDR_W-1:0] target;

   assign eff_addr = base_addr_i + {{IEXT_W{1'b0}}, index_i};
   assign next_pc  = pc_i + ADDR_W'(2);
   assign target   = next_pc + {{EXT_W{br_off_i[7]}}, br_off_i};

   assign idx_cross_o = eff_addr[PAGE_MSB:PAGE_BITS] != base_addr_i[PAGE_MSB:PAGE_BITS];
   assign br_cross_o  = target[PAGE_MSB:PAGE_BITS]   != next_pc[PAGE_MSB:PAGE_BITS];

endmodule

// File: rtl/cycle_tally.sv
module cycle_tally #(
   parameter int  ACC_W    = 32,
   parameter int  AMT_W    = 4,
   parameter bit  TALLY_EN = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             add_en_i,
   input  logic [AMT_W-1:0] amt_i,
   output logic [ACC_W-1:0] sum_o
);

   localparam int PAD_W = ACC_W - AMT_W;

   generate
      if (TALLY_EN) begin : g_tally
         logic [ACC_W-1:0] sum_q;
         always_ff @(posedge clk_i) begin
            if (rst_i)         sum_q <= '0;
            else if (add_en_i) sum_q <= sum_q + {{PAD_W{1'b0}}, amt_i};
         end
         assign sum_o = sum_q;
      end else begin : g_no_tally
         logic unused_tally;
         assign unused_tally = ^{clk_i, rst_i, add_en_i, amt_i};
         assign sum_o = '0;
      end
   endgenerate

endmodule

// File: rtl/instr_timing.sv
module instr_timing
   import instr_timing_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int PAGE_BITS = 8,
   parameter int IDX_W     = 8,
   parameter int ACC_W     = 32,
   parameter bit TALLY_EN  = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              valid_i,
   input  logic [7:0]        opcode_i,
   input  logic [ADDR_W-1:0] base_addr_i,
   input  logic [IDX_W-1:0]  idx_x_i,
   input  logic [IDX_W-1:0]  idx_y_i,
   input  logic [7:0]        br_off_i,
   input  logic              br_taken_i,
   input  logic [ADDR_W-1:0] pc_i,
   output logic [LEN_W-1:0]  len_o,
   output logic [3:0]        mode_o,
   output logic [CYC_W-1:0]  base_cyc_o,
   output logic [CYC_W-1:0]  total_cyc_o,
   output logic              illegal_o,
   output logic [ACC_W-1:0]  tally_o
);

   generate
      if (ADDR_W <= PAGE_BITS || ADDR_W < 9) begin : g_bad_addr
         $error("instr_timing: ADDR_W must exceed PAGE_BITS and 8");
      end
      if (IDX_W > ADDR_W || IDX_W < 1) begin : g_bad_idx
         $error("instr_timing: IDX_W out of range");
      end
      if (ACC_W <= CYC_W) begin : g_bad_acc
         $error("instr_timing: ACC_W must exceed the cycle width");
      end
   endgenerate

   op_info_t         info;
   logic [IDX_W-1:0] pen_index;
   logic             idx_cross;
   logic             br_cross;
   logic             pay_idx;
   logic             pay_take;
   logic             pay_far;

   opc_decode u_dec (
      .opcode_i (opcode_i),
      .info_o   (info)
   );

   assign pen_index = info.use_y ? idx_y_i : idx_x_i;

   page_cross #(
      .ADDR_W    (ADDR_W),
      .PAGE_BITS (PAGE_BITS),
      .IDX_W     (IDX_W)
   ) u_page (
      .base_addr_i (base_addr_i),
      .index_i     (pen_index),
      .pc_i        (pc_i),
      .br_off_i    (br_off_i),
      .idx_cross_o (idx_cross),
      .br_cross_o  (br_cross)
   );

   assign pay_idx  = info.idx_pen & idx_cross;
   assign pay_take = info.branch & br_taken_i;
   assign pay_far  = pay_take & br_cross;

   assign len_o       = info.len;
   assign mode_o      = info.mode;
   assign base_cyc_o  = info.base_cyc;
   assign illegal_o   = info.illegal;
   assign total_cyc_o = info.base_cyc
                      + {{(CYC_W-1){1'b0}}, pay_idx}
                      + {{(CYC_W-1){1'b0}}, pay_take}
                      + {{(CYC_W-1){1'b0}}, pay_far};

   cycle_tally #(
      .ACC_W    (ACC_W),
      .AMT_W    (CYC_W),
      .TALLY_EN (TALLY_EN)
   ) u_tally (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .add_en_i (valid_i & ~info.illegal),
      .amt_i    (total_cyc_o),
      .sum_o    (tally_o)
   );

endmodule

// File: rtl/instr_timing_chk.sv
module instr_timing_chk #(
   parameter int ACC_W    = 32,
   parameter bit TALLY_EN = 1'b1
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic             valid_i,
   input logic [7:0]       opcode_i,
   input logic             br_taken_i,
   input logic [1:0]       len_o,
   input logic [3:0]       mode_o,
   input logic [3:0]       base_cyc_o,
   input logic [3:0]       total_cyc_o,
   input logic             illegal_o,
   input logic [ACC_W-1:0] tally_o
);

   p_len_three_r1: assert property (@(posedge clk_i) disable iff (rst_i)
      (mode_o inside {4'd6, 4'd7, 4'd8, 4'd9}) |-> len_o == 2'd3);

   p_store_fixed_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      (opcode_i[1:0] == 2'b01 && opcode_i[7:5] == 3'd4 && !illegal_o)
      |-> total_cyc_o == base_cyc_o);

   p_penalty_bound_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      !illegal_o |-> (total_cyc_o >= base_cyc_o) && (total_cyc_o <= base_cyc_o + 4'd2));

   p_branch_idle_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      (mode_o == 4'd12 && !br_taken_i) |-> total_cyc_o == 4'd2);

   p_illegal_quiet_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      illegal_o |-> (total_cyc_o == 4'd0 && len_o == 2'd1 && mode_o == 4'd0));

   p_group3_illegal_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      (opcode_i[1:0] == 2'b11) |-> illegal_o);

   p_tally_add_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      (TALLY_EN && valid_i && !illegal_o)
      |=> tally_o == $past(tally_o) + ACC_W'($past(total_cyc_o)));

   p_tally_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      (!valid_i || illegal_o) |=> $stable(tally_o));

   p_reset_clear_r10: assert property (@(posedge clk_i)
      rst_i |=> tally_o == '0);

endmodule

bind instr_timing instr_timing_chk #(
   .ACC_W    (ACC_W),
   .TALLY_EN (TALLY_EN)
) u_chk (
   .clk_i       (clk_i),
   .rst_i       (rst_i),
   .valid_i     (valid_i),
   .opcode_i    (opcode_i),
   .br_taken_i  (br_taken_i),
   .len_o       (len_o),
   .mode_o      (mode_o),
   .base_cyc_o  (base_cyc_o),
   .total_cyc_o (total_cyc_o),
   .illegal_o   (illegal_o),
   .tally_o     (tally_o)
);

// File: tb/instr_timing_bench.sv
module instr_timing_bench;

   typedef struct packed {
      logic [7:0]  op;
      logic [15:0] base;
      logic [7:0]  x;
      logic [7:0]  y;
      logic [7:0]  off;
      logic        tk;
      logic [15:0] pc;
      logic [1:0]  len;
      logic [3:0]  mode;
      logic [3:0]  bc;
      logic [3:0]  tc;
      logic        ill;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 46;

   localparam vec_t TBL [NV] = '{
      // R3 reads, R2 modes, R1 lengths
      '{8'hA9, 16'h0000, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0000, 2'd2, 4'd2,  4'd2, 4'd2, 1'b0, 4'd3},
      '{8'hA5, 16'h0000, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0000, 2'd2, 4'd3,  4'd3, 4'd3, 1'b0, 4'd3},
      '{8'hB5, 16'h00F0, 8'h40, 8'h00, 8'h00, 1'b0, 16'h0000, 2'd2, 4'd4,  4'd4, 4'd4, 1'b0, 4'd3},
      '{8'hAD, 16'h1234, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0000, 2'd3, 4'd6,  4'd4, 4'd4, 1'b0, 4'd3},
      '{8'hA1, 16'h00FF, 8'hFF, 8'hFF, 8'h00, 1'b0, 16'h0000, 2'd2, 4'd10, 4'd6, 4'd6, 1'b0, 4'd3},
      '{8'h69, 16'h0000, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0000, 2'd2, 4'd2,  4'd2, 4'd2, 1'b0, 4'd3},
      '{8'h2C, 16'h4000, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0000, 2'd3, 4'd6,  4'd4, 4'd4, 1'b0, 4'd3},
      '{8'h24, 16'h0010, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0000, 2'd2, 4'd3,  4'd3, 4'd3, 1'b0, 4'd3},
      '{8'hA2, 16'h0000, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0000, 2'd2, 4'd2,  4'd2, 4'd2, 1'b0, 4'd2},
      '{8'hB6, 16'h0080, 8'h00, 8'h05, 8'h00, 1'b0, 16'h0000, 2'd2, 4'd5,  4'd4, 4'd4, 1'b0, 4'd2},
      '{8'h96, 16'h0080, 8'h00, 8'h05, 8'h00, 1'b0, 16'h0000, 2'd2, 4'd5,  4'd4, 4'd4, 1'b0, 4'd2},
      // R6 indexed read page penalty
      '{8'hBD, 16'h12F0, 8'h20, 8'h00, 8'h00, 1'b0, 16'h0000, 2'd3, 4'd7,  4'd4, 4'd5, 1'b0, 4'd6},
      '{8'hBD, 16'h1200, 8'h10, 8'hFF, 8'h00, 1'b0, 16'h0000, 2'd3, 4'd7,  4'd4, 4'd4, 1'b0, 4'd6},
      '{8'hBD, 16'h12F0, 8'h0F, 8'h00, 8'h00, 1'b0, 16'h0000, 2'd3, 4'd7,  4'd4, 4'd4, 1'b0, 4'd6},
      '{8'hB9, 16'h20FF, 8'h00, 8'h01, 8'h00, 1'b0, 16'h0000, 2'd3, 4'd8,  4'd4, 4'd5, 1'b0, 4'd6},
      '{8'hB9, 16'h20FF, 8'hFF, 8'h00, 8'h00, 1'b0, 16'h0000, 2'd3, 4'd8,  4'd4, 4'd4, 1'b0, 4'd6},
      '{8'hB1, 16'h30FE, 8'h00, 8'h02, 8'h00, 1'b0, 16'h0000, 2'd2, 4'd11, 4'd5, 4'd6, 1'b0, 4'd6},
      '{8'hBE, 16'h12F8, 8'h00, 8'h10, 8'h00, 1'b0, 16'h0000, 2'd3, 4'd8,  4'd4, 4'd5, 1'b0, 4'd6},
      '{8'hBC, 16'h12F8, 8'h10, 8'h00, 8'h00, 1'b0, 16'h0000, 2'd3, 4'd7,  4'd4, 4'd5, 1'b0, 4'd6},
      '{8'hFD, 16'hFFF0, 8'h20, 8'h00, 8'h00, 1'b0, 16'h0000, 2'd3, 4'd7,  4'd4, 4'd5, 1'b0, 4'd6},
      // R4 stores and read-modify-write
      '{8'h9D, 16'h12F0, 8'h20, 8'h00, 8'h00, 1'b0, 16'h0000, 2'd3, 4'd7,  4'd5, 4'd5, 1'b0, 4'd4},
      '{8'h99, 16'h20FF, 8'h00, 8'h01, 8'h00, 1'b0, 16'h0000, 2'd3, 4'd8,  4'd5, 4'd5, 1'b0, 4'd4},
      '{8'h91, 16'h30FE, 8'h00, 8'h02, 8'h00, 1'b0, 16'h0000, 2'd2, 4'd11, 4'd6, 4'd6, 1'b0, 4'd4},
      '{8'h06, 16'h0000, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0000, 2'd2, 4'd3,  4'd5, 4'd5, 1'b0, 4'd4},
      '{8'h16, 16'h0000, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0000, 2'd2, 4'd4,  4'd6, 4'd6, 1'b0, 4'd4},
      '{8'h0E, 16'h0000, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0000, 2'd3, 4'd6,  4'd6, 4'd6, 1'b0, 4'd4},
      '{8'h1E, 16'h12F0, 8'h20, 8'h00, 8'h00, 1'b0, 16'h0000, 2'd3, 4'd7,  4'd7, 4'd7, 1'b0, 4'd4},
      '{8'h0A, 16'h0000, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0000, 2'd1, 4'd1,  4'd2, 4'd2, 1'b0, 4'd4},
      // R5 control flow, stack, implied
      '{8'h4C, 16'h0000, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0000, 2'd3, 4'd6,  4'd3, 4'd3, 1'b0, 4'd5},
      '{8'h6C, 16'h0000, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0000, 2'd3, 4'd9,  4'd5, 4'd5, 1'b0, 4'd5},
      '{8'h20, 16'h0000, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0000, 2'd3, 4'd6,  4'd6, 4'd6, 1'b0, 4'd5},
      '{8'h60, 16'h0000, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0000, 2'd1, 4'd0,  4'd6, 4'd6, 1'b0, 4'd5},
      '{8'h40, 16'h0000, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0000, 2'd1, 4'd0,  4'd6, 4'd6, 1'b0, 4'd5},
      '{8'h00, 16'h0000, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0000, 2'd1, 4'd0,  4'd7, 4'd7, 1'b0, 4'd5},
      '{8'h48, 16'h0000, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0000, 2'd1, 4'd0,  4'd3, 4'd3, 1'b0, 4'd5},
      '{8'h28, 16'h0000, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0000, 2'd1, 4'd0,  4'd4, 4'd4, 1'b0, 4'd5},
      '{8'hCA, 16'h0000, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0000, 2'd1, 4'd0,  4'd2, 4'd2, 1'b0, 4'd5},
      '{8'h9A, 16'h0000, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0000, 2'd1, 4'd0,  4'd2, 4'd2, 1'b0, 4'd5},
      // R7 branches
      '{8'hD0, 16'h0000, 8'h00, 8'h00, 8'h80, 1'b0, 16'h10F0, 2'd2, 4'd12, 4'd2, 4'd2, 1'b0, 4'd7},
      '{8'hD0, 16'h0000, 8'h00, 8'h00, 8'h10, 1'b1, 16'h1000, 2'd2, 4'd12, 4'd2, 4'd3, 1'b0, 4'd7},
      '{8'hD0, 16'h0000, 8'h00, 8'h00, 8'h20, 1'b1, 16'h10F0, 2'd2, 4'd12, 4'd2, 4'd4, 1'b0, 4'd7},
      '{8'hF0, 16'h0000, 8'h00, 8'h00, 8'hF0, 1'b1, 16'h1000, 2'd2, 4'd12, 4'd2, 4'd4, 1'b0, 4'd7},
      '{8'h10, 16'h0000, 8'h00, 8'h00, 8'h05, 1'b1, 16'h10FE, 2'd2, 4'd12, 4'd2, 4'd3, 1'b0, 4'd7},
      '{8'h90, 16'h0000, 8'h00, 8'h00, 8'h01, 1'b1, 16'hFFFE, 2'd2, 4'd12, 4'd2, 4'd3, 1'b0, 4'd7},
      // R8 illegal opcodes
      '{8'h80, 16'h0000, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0000, 2'd1, 4'd0,  4'd0, 4'd0, 1'b1, 4'd8},
      '{8'h89, 16'h0000, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0000, 2'd1, 4'd0,  4'd0, 4'd0, 1'b1, 4'd8}
   };

   localparam logic [7:0] EXTRA_ILL [10] = '{8'h02, 8'h03, 8'hFF, 8'h9E, 8'h04,
                                             8'h0C, 8'h1A, 8'h3C, 8'h44, 8'hD4};

   logic        clk;
   logic        rst;
   logic        valid;
   logic [7:0]  opcode;
   logic [15:0] base_addr;
   logic [7:0]  idx_x;
   logic [7:0]  idx_y;
   logic [7:0]  br_off;
   logic        br_taken;
   logic [15:0] pc;
   logic [1:0]  len;
   logic [3:0]  mode;
   logic [3:0]  base_cyc;
   logic [3:0]  total_cyc;
   logic        illegal;
   logic [31:0] tally;

   int checks = 0;
   int fails  = 0;
   longint exp_sum;

   instr_timing u_instr_timing (
      .clk_i       (clk),
      .rst_i       (rst),
      .valid_i     (valid),
      .opcode_i    (opcode),
      .base_addr_i (base_addr),
      .idx_x_i     (idx_x),
      .idx_y_i     (idx_y),
      .br_off_i    (br_off),
      .br_taken_i  (br_taken),
      .pc_i        (pc),
      .len_o       (len),
      .mode_o      (mode),
      .base_cyc_o  (base_cyc),
      .total_cyc_o (total_cyc),
      .illegal_o   (illegal),
      .tally_o     (tally)
   );

   initial clk = 1'b0;
   always #5 clk = ~clk;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic drive(input vec_t v, input logic vld);
      opcode    = v.op;
      base_addr = v.base;
      idx_x     = v.x;
      idx_y     = v.y;
      br_off    = v.off;
      br_taken  = v.tk;
      pc        = v.pc;
      valid     = vld;
   endtask

   function automatic vec_t ill_vec(input logic [7:0] op);
      ill_vec = '{op, 16'h12F0, 8'h20, 8'h20, 8'h40, 1'b1, 16'h10F0,
                  2'd1, 4'd0, 4'd0, 4'd0, 1'b1, 4'd8};
   endfunction

   task automatic check_vec(input vec_t v);
      logic [14:0] act;
      logic [14:0] exp;
      act = {len, mode, base_cyc, total_cyc, illegal};
      exp = {v.len, v.mode, v.bc, v.tc, v.ill};
      check(act == exp, $sformatf("R%0d", v.rq),
            $sformatf("opcode %h {len,mode,base,total,ill}", v.op),
            64'(act), 64'(exp));
   endtask

   initial begin
      #1_000_000;
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      rst = 1'b1;
      drive(TBL[0], 1'b0);
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #2;
      // R10 reset state of the tally
      check(tally == 32'd0, "R10", "tally after reset", 64'(tally), 64'd0);

      // table walk: every vector is also counted into the tally (R9)
      exp_sum = 0;
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(TBL[i], 1'b1);
         #2;
         check_vec(TBL[i]);
         if (!TBL[i].ill) exp_sum += TBL[i].tc;
      end
      // R8 extra illegal opcodes, with context that would add penalties
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         drive(ill_vec(EXTRA_ILL[i]), 1'b1);
         #2;
         check_vec(ill_vec(EXTRA_ILL[i]));
      end
      @(negedge clk);
      valid = 1'b0;
      #2;
      check(tally == 32'(exp_sum), "R9", "tally after table walk", 64'(tally), 64'(exp_sum));

      // R9 no strobe: legal opcode held without valid
      drive(TBL[33], 1'b0);
      repeat (3) @(negedge clk);
      #2;
      check(tally == 32'(exp_sum), "R9", "tally without strobe", 64'(tally), 64'(exp_sum));

      // R9 illegal opcode with strobe adds nothing
      drive(ill_vec(8'hFF), 1'b1);
      repeat (2) @(negedge clk);
      valid = 1'b0;
      #2;
      check(tally == 32'(exp_sum), "R9", "tally after illegal strobes", 64'(tally), 64'(exp_sum));

      // R9 one BRK strobe adds 7
      drive(TBL[33], 1'b1);
      @(negedge clk);
      valid = 1'b0;
      exp_sum += 7;
      #2;
      check(tally == 32'(exp_sum), "R9", "tally after one BRK", 64'(tally), 64'(exp_sum));

      // R7 taken branch across page with tally: adds 4
      drive(TBL[40], 1'b1);
      @(negedge clk);
      valid = 1'b0;
      exp_sum += 4;
      #2;
      check(tally == 32'(exp_sum), "R7", "tally after far branch", 64'(tally), 64'(exp_sum));

      // R10 reset wins over a strobe
      rst = 1'b1;
      drive(TBL[33], 1'b1);
      @(negedge clk);
      rst   = 1'b0;
      valid = 1'b0;
      #2;
      check(tally == 32'd0, "R10", "tally after reset with strobe", 64'(tally), 64'd0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule